// File: doc/BRIEF.md
# Serial Setpoint Command Decoder

This block is a write-only, three-wire serial slave that owns two 10-bit setpoint values for a pair of converters downstream. A host frames a 16-bit word by pulling an active-low load line low, shifts bits in on the serial clock's rising edges (most significant bit first), and then releases the load line. On that release, a 4-bit operation code at the top of the word decides three separate things: which of two staged (input) registers take the 10-bit data field, whether the staged pair is copied into the live (output) registers, and whether the sleep status changes.

All three serial lines come from outside the block's clock domain. Each passes through a two-stage synchronizer, and edges are found in the system clock domain. The system clock must therefore run at least four times faster than the serial clock. Any frame that ends before 16 rising serial-clock edges have been seen is dropped without effect. Every transfer into the live registers raises a one-cycle update strobe.

Top module: `spt_cmd_decoder`

## Requirements
- R1: A frame opens when `ser_load_n` falls. Each `ser_clk` rising edge while `ser_load_n` is low takes one `ser_data` bit, most significant first. Word bits [15:12] are the operation code, bits [11:2] are the data value, and bits [1:0] are ignored.
- R2: A word is acted on only at the rising edge of `ser_load_n`, and only if at least 16 `ser_clk` rising edges were seen in that frame.
- R3: A frame that closes after fewer than 16 edges changes neither `set_a`, `set_b` nor `sleep`, and it raises no `upd_stb`.
- R4: Once 16 bits are in, further `ser_clk` edges in the same frame are ignored, so the word is the first 16 bits.
- R5: Code 0001 stages the data value for A, and code 0010 stages it for B. Neither changes the outputs, `sleep` or `upd_stb`.
- R6: Code 1000 copies both staged values to `set_a`/`set_b`. Code 1001 first stages the data value for A and then copies both. Code 1010 first stages it for B and then copies both. All three clear `sleep`.
- R7: Code 1110 sets `sleep` to 1, and code 1101 clears it to 0. Neither changes any register.
- R8: Code 1111 writes the data value to both staged and both live registers and clears `sleep`.
- R9: Codes 0000, 0011 to 0111, 1011 and 1100 have no effect on any output.
- R10: After reset, `set_a` = 943, `set_b` = 40 and `sleep` = 0. Both staged registers also hold 943 and 40, so a following code 1000 leaves the outputs at those values.
- R11: While `sleep` is 1, every register keeps its value and frames are still decoded.
- R12: `upd_stb` is high for exactly one cycle, in the cycle `set_a`/`set_b` take their values from a copy (codes 1000, 1001, 1010, 1111). It is low at every other time.
- R13: The serial lines are synchronized into `clk`. Each `ser_clk` high and low phase must last at least two `clk` periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock, asynchronous to `clk` |
| ser_data | input | 1 | Serial data, sampled on `ser_clk` rising edges |
| ser_load_n | input | 1 | Active-low frame and load line |
| set_a | output | 10 | Live setpoint A (upper) |
| set_b | output | 10 | Live setpoint B (lower) |
| sleep | output | 1 | Sleep status, 1 = asleep |
| upd_stb | output | 1 | One-cycle pulse when the live registers are written |

## Verification
A staged register that is wrong stays hidden until the next copy code. The checks therefore follow every staging write with a copy and compare `set_a`/`set_b` a few cycles after `ser_load_n` rises. A bit counter that miscounts shows up in two ways. Either a short frame changes the outputs, or a full frame has no effect. Each expected copy is queued, so a missing or extra `upd_stb` is caught in the cycle it occurs.

// File: rtl/spt_pkg.sv
package spt_pkg;

    localparam int WORD_W = 16;
    localparam int CODE_W = 4;
    localparam int DATA_W = 10;
    localparam int PAD_W  = WORD_W - CODE_W - DATA_W;
    localparam int CNT_W  = $clog2(WORD_W + 1);

    localparam logic [DATA_W-1:0] RESET_A = DATA_W'(943);
    localparam logic [DATA_W-1:0] RESET_B = DATA_W'(40);

    typedef enum logic [CODE_W-1:0] {
        OP_NOP       = 4'b0000,
        OP_STAGE_A   = 4'b0001,
        OP_STAGE_B   = 4'b0010,
        OP_COPY      = 4'b1000,
        OP_STAGE_A_C = 4'b1001,
        OP_STAGE_B_C = 4'b1010,
        OP_WAKE      = 4'b1101,
        OP_SLEEP     = 4'b1110,
        OP_ALL       = 4'b1111
    } op_e;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [DATA_W-1:0] data;
        logic [PAD_W-1:0]  pad;
    } frame_t;

    typedef struct packed {
        logic stage_a;
        logic stage_b;
        logic copy;
        logic wake;
        logic go_sleep;
    } action_t;

    function automatic action_t decode_op(input logic [CODE_W-1:0] code);
        action_t act;
        act = '0;
        case (code)
            OP_STAGE_A:   act.stage_a = 1'b1;
            OP_STAGE_B:   act.stage_b = 1'b1;
            OP_COPY:      begin act.copy = 1'b1; act.wake = 1'b1; end
            OP_STAGE_A_C: begin act.stage_a = 1'b1; act.copy = 1'b1; act.wake = 1'b1; end
            OP_STAGE_B_C: begin act.stage_b = 1'b1; act.copy = 1'b1; act.wake = 1'b1; end
            OP_WAKE:      act.wake = 1'b1;
            OP_SLEEP:     act.go_sleep = 1'b1;
            OP_ALL:       begin
                act.stage_a = 1'b1; act.stage_b = 1'b1;
                act.copy = 1'b1; act.wake = 1'b1;
            end
            default:      act = '0;
        endcase
        return act;
    endfunction

endpackage

// File: rtl/spt_line_sync.sv
module spt_line_sync #(
    parameter int              WIDTH  = 3,
    parameter int              STAGES = 2,
    parameter logic [WIDTH-1:0] IDLE  = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    logic [WIDTH-1:0] stg [STAGES];
    logic [WIDTH-1:0] prev_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= IDLE;
                    else     stg[s] <= raw;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= IDLE;
                    else     stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= IDLE;
        else     prev_q <= stg[STAGES-1];
    end

    assign level = stg[STAGES-1];
    assign rise  = stg[STAGES-1] & ~prev_q;
    assign fall  = ~stg[STAGES-1] & prev_q;

endmodule

// File: rtl/spt_frame_shifter.sv
module spt_frame_shifter
    import spt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sck_rise,
    input  logic   din,
    input  logic   sel_low,
    input  logic   sel_fall,
    input  logic   sel_rise,
    output logic   frame_vld,
    output frame_t frame_word
);
    logic [WORD_W-1:0] shreg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              full;

    assign full = (cnt_q == CNT_W'(WORD_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q    <= '0;
            cnt_q      <= '0;
            frame_vld  <= 1'b0;
            frame_word <= '0;
        end else begin
            frame_vld <= 1'b0;
            if (sel_fall) begin
                shreg_q <= '0;
                cnt_q   <= '0;
            end else if (sel_rise) begin
                if (full) begin
                    frame_vld  <= 1'b1;
                    frame_word <= frame_t'(shreg_q);
                end
                shreg_q <= '0;
                cnt_q   <= '0;
            end else if (sck_rise && sel_low && !full) begin
                shreg_q <= {shreg_q[WORD_W-2:0], din};
                cnt_q   <= cnt_q + 1'b1;
            end
        end
    end

    // R4: edges after the 16th leave the captured word alone
    a_r4_extra_edges_ignored: assert property (@(posedge clk) disable iff (rst)
        (sck_rise && full && !sel_fall && !sel_rise) |=> $stable(shreg_q));

    // R2: counter never exceeds the word length
    a_r2_count_bounded: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(WORD_W));

endmodule

// File: rtl/spt_reg_bank.sv
module spt_reg_bank
    import spt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_vld,
    input  frame_t            frame_word,
    output logic [DATA_W-1:0] live_a,
    output logic [DATA_W-1:0] live_b,
    output logic              sleep_q,
    output logic              stb_q
);
    action_t           act;
    logic [DATA_W-1:0] stg_a_q, stg_b_q;
    logic [DATA_W-1:0] stg_a_n, stg_b_n;

    always_comb begin
        act     = frame_vld ? decode_op(frame_word.code) : '0;
        stg_a_n = act.stage_a ? frame_word.data : stg_a_q;
        stg_b_n = act.stage_b ? frame_word.data : stg_b_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_a_q <= RESET_A;
            stg_b_q <= RESET_B;
            live_a  <= RESET_A;
            live_b  <= RESET_B;
            sleep_q <= 1'b0;
            stb_q   <= 1'b0;
        end else begin
            stg_a_q <= stg_a_n;
            stg_b_q <= stg_b_n;
            stb_q   <= act.copy;
            if (act.copy) begin
                live_a <= stg_a_n;
                live_b <= stg_b_n;
            end
            if (act.wake)          sleep_q <= 1'b0;
            else if (act.go_sleep) sleep_q <= 1'b1;
        end
    end

    // R3: with no accepted frame, outputs hold
    a_r3_hold_without_frame: assert property (@(posedge clk) disable iff (rst)
        !frame_vld |=> ($stable(live_a) && $stable(live_b) && $stable(sleep_q)));

    // R5: staging-only codes never touch the live registers
    a_r5_stage_only: assert property (@(posedge clk) disable iff (rst)
        (frame_vld && (frame_word.code == OP_STAGE_A || frame_word.code == OP_STAGE_B))
        |=> ($stable(live_a) && $stable(live_b) && !stb_q));

    // R6: every copy leaves the block awake
    a_r6_copy_wakes: assert property (@(posedge clk) disable iff (rst)
        stb_q |-> !sleep_q);

endmodule

// File: rtl/spt_cmd_decoder.sv
module spt_cmd_decoder
    import spt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_load_n,
    output logic [DATA_W-1:0] set_a,
    output logic [DATA_W-1:0] set_b,
    output logic              sleep,
    output logic              upd_stb
);
    localparam int LINES = 3;
    localparam int L_SCK = 0;
    localparam int L_DIN = 1;
    localparam int L_SEL = 2;

    logic [LINES-1:0] lvl, rise, fall;
    logic             frame_vld;
    frame_t           frame_word;

    spt_line_sync #(
        .WIDTH (LINES),
        .STAGES(SYNC_STAGES),
        .IDLE  (3'b100)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .raw  ({ser_load_n, ser_data, ser_clk}),
        .level(lvl),
        .rise (rise),
        .fall (fall)
    );

    spt_frame_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .sck_rise  (rise[L_SCK]),
        .din       (lvl[L_DIN]),
        .sel_low   (!lvl[L_SEL]),
        .sel_fall  (fall[L_SEL]),
        .sel_rise  (rise[L_SEL]),
        .frame_vld (frame_vld),
        .frame_word(frame_word)
    );

    spt_reg_bank u_bank (
        .clk       (clk),
        .rst       (rst),
        .frame_vld (frame_vld),
        .frame_word(frame_word),
        .live_a    (set_a),
        .live_b    (set_b),
        .sleep_q   (sleep),
        .stb_q     (upd_stb)
    );

    // R12: the update strobe lasts a single cycle
    a_r12_single_pulse: assert property (@(posedge clk) disable iff (rst)
        upd_stb |=> !upd_stb);

    // R2: no action without a load-line release
    a_r2_act_after_release: assert property (@(posedge clk) disable iff (rst)
        frame_vld |-> lvl[L_SEL]);

endmodule

// File: tb/spt_cmd_decoder_test.sv
module spt_cmd_decoder_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_load_n = 1'b1;
    logic [9:0] set_a, set_b;
    logic sleep, upd_stb;

    int tests = 0;
    int failed = 0;

    logic [9:0] m_sa = 10'd943, m_sb = 10'd40, m_la = 10'd943, m_lb = 10'd40;
    logic m_sleep = 1'b0;
    logic [19:0] exp_q[$];

    always #10 clk = ~clk;

    spt_cmd_decoder uut (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_load_n(ser_load_n), .set_a(set_a), .set_b(set_b),
        .sleep(sleep), .upd_stb(upd_stb)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            failed++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // scoreboard monitor: each strobe must match a queued copy (R12)
    always @(negedge clk) begin
        if (!rst && upd_stb) begin
            tests++;
            if (exp_q.size() == 0) begin
                failed++;
                $display("FAIL R12 actual=unexpected strobe expected=none");
            end else begin
                logic [19:0] e;
                e = exp_q.pop_front();
                if ({set_a, set_b} != e) begin
                    failed++;
                    $display("FAIL R12 actual=%0d/%0d expected=%0d/%0d",
                             set_a, set_b, e[19:10], e[9:0]);
                end
            end
        end
    end

    task automatic model(input logic [3:0] code, input logic [9:0] data);
        logic cp;
        cp = 1'b0;
        case (code)
            4'b0001: m_sa = data;
            4'b0010: m_sb = data;
            4'b1000: cp = 1'b1;
            4'b1001: begin m_sa = data; cp = 1'b1; end
            4'b1010: begin m_sb = data; cp = 1'b1; end
            4'b1101: m_sleep = 1'b0;
            4'b1110: m_sleep = 1'b1;
            4'b1111: begin m_sa = data; m_sb = data; cp = 1'b1; end
            default: ;
        endcase
        if (cp) begin
            m_la = m_sa; m_lb = m_sb; m_sleep = 1'b0;
            exp_q.push_back({m_la, m_lb});
        end
    endtask

    // driver: nbits of the word, then extra edges with data 1
    task automatic send(input logic [3:0] code, input logic [9:0] data,
                        input int nbits, input int extra);
        logic [15:0] w;
        w = {code, data, 2'b10};
        @(negedge clk) ser_load_n = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < nbits + extra; i++) begin
            ser_data = (i < 16) ? w[15-i] : 1'b1;
            repeat (2) @(negedge clk);
            ser_clk = 1'b1;
            repeat (3) @(negedge clk);
            ser_clk = 1'b0;
        end
        repeat (3) @(negedge clk);
        if (nbits >= 16) model(code, data);
        ser_load_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic chk_all(input string req);
        chk(req, set_a, m_la);
        chk(req, set_b, m_lb);
        chk(req, sleep, m_sleep);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 reset a", set_a, 943);
        chk("R10 reset b", set_b, 40);
        chk("R10 reset sleep", sleep, 0);

        send(4'b1000, 10'd0, 16, 0);   chk_all("R10 staged defaults");
        send(4'b0001, 10'd100, 16, 0); chk_all("R5 stage A");
        send(4'b0010, 10'd200, 16, 0); chk_all("R5 stage B");
        send(4'b1000, 10'd0, 16, 0);   chk_all("R6 copy");
        chk("R1 data field", set_a, 100);
        send(4'b1001, 10'd300, 16, 0); chk_all("R6 stage A and copy");
        send(4'b1010, 10'd400, 16, 0); chk_all("R6 stage B and copy");
        send(4'b1111, 10'd1023, 16, 0); chk_all("R8 all max");
        send(4'b1111, 10'd5, 16, 0);   chk_all("R8 all");
        chk("R8 value", set_b, 5);

        send(4'b0000, 10'd11, 16, 0); chk_all("R9 code 0000");
        send(4'b0011, 10'd12, 16, 0); chk_all("R9 code 0011");
        send(4'b0111, 10'd13, 16, 0); chk_all("R9 code 0111");
        send(4'b1011, 10'd14, 16, 0); chk_all("R9 code 1011");
        send(4'b1100, 10'd15, 16, 0); chk_all("R9 code 1100");
        send(4'b1000, 10'd0, 16, 0);  chk_all("R9 staging untouched");

        send(4'b1111, 10'd77, 15, 0); chk_all("R3 short 15");
        send(4'b1110, 10'd0, 1, 0);   chk_all("R3 short 1");
        send(4'b1111, 10'd0, 0, 0);   chk_all("R2 empty frame");

        send(4'b1110, 10'd0, 16, 0);   chk_all("R7 sleep");
        chk("R7 sleep set", sleep, 1);
        send(4'b0001, 10'd123, 16, 0); chk_all("R11 stage while asleep");
        chk("R11 still asleep", sleep, 1);
        send(4'b1101, 10'd0, 16, 0);   chk_all("R7 wake");
        chk("R7 wake no copy", set_a, 5);
        send(4'b1110, 10'd0, 16, 0);   chk_all("R7 sleep again");
        send(4'b1000, 10'd0, 16, 0);   chk_all("R11 copy wakes");
        chk("R11 staged kept", set_a, 123);

        send(4'b1001, 10'h2AA, 16, 6); chk_all("R4 extra edges");
        chk("R4 value", set_a, 682);
        send(4'b1010, 10'd0, 16, 3);   chk_all("R13 zero data");

        chk("R12 queue drained", exp_q.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        failed++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

endmodule